// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block runs the built-in self test of a dot-matrix display controller. A host starts it by writing the control word with the start bit set. The sequencer first reads every word of the character-decoder ROM, one address per clock, and adds the words into a checksum. It then forces a checkerboard onto the LED columns, followed by the inverse checkerboard, so that a person can see every dot light.

The whole run has a fixed length of `TEST_LEN` clocks. At the end the sequencer stores the checksum verdict as a read-only pass bit and clears the rest of the control word. It also pulses a one-cycle request so that the surrounding controller can reinitialise its storage. That storage is blank characters in the character RAM, a cleared flash RAM, and an all-ones user-character address.

The ROM itself sits outside the block. The block drives its address and reads its data combinationally in the same cycle. The display scanner tells the block whether the row being driven has an odd index.

Top module: `selftest_seq`

## Requirements
- R1: After reset, `busy`, `pass`, `init_req` and `pat_force` are 0, `ctl_rdata` reads 0x00 and `pat_cols` is 0.
- R2: While idle, a write whose bit 6 (start) is 1 starts a test: `busy` is 1 from the next cycle, and `ctl_rdata` bit 6 reads 1 throughout the run.
- R3: `busy` stays 1 for exactly `TEST_LEN` consecutive cycles per test.
- R4: In test cycle k, for k below 2^`ROM_AW`, `rom_addr` equals k, so the ROM is swept in ascending order.
- R5: The checksum is the sum modulo 2^`SUM_W` of all ROM words. When the test ends, `pass` (and `ctl_rdata` bit 5) becomes 1 if the checksum equals `EXPECT_SUM` and 0 otherwise. Its value is kept until the next test ends.
- R6: For the `PAT_LEN` cycles after the sweep, `pat_force` is 1 and column c is lit when the parity of c equals `scan_odd_row`, which gives a checkerboard.
- R7: For the next `PAT_LEN` cycles, `pat_force` is 1 and column c is lit when the parity of c differs from `scan_odd_row`, which gives the inverse checkerboard.
- R8: In every other cycle, including idle time and the tail of a test, `pat_force` and `pat_cols` are 0.
- R9: In the first cycle after `busy` falls, `init_req` is 1 for exactly one cycle, and `ctl_rdata` has every bit except bit 5 cleared, including the start bit.
- R10: Writes while `busy` is 1 are ignored: `ctl_rdata` and the test length do not change.
- R11: Bit 5 of a write is discarded; only the end of a test changes `pass`.
- R12: While idle, a write with bit 6 clear stores bits 7 and 4..0, which read back unchanged on `ctl_rdata`, and starts no test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| ctl_rdata | output | 8 | Control word read value, with bit 5 holding the result |
| rom_addr | output | ROM_AW | Character ROM address |
| rom_data | input | ROM_DW | Character ROM data, valid in the same cycle |
| scan_odd_row | input | 1 | Row currently being driven has an odd index |
| pat_force | output | 1 | Test pattern overrides normal column data |
| pat_cols | output | COLS | Test pattern column drive |
| busy | output | 1 | Test in progress |
| pass | output | 1 | Result of the last completed test |
| init_req | output | 1 | One-cycle request to reinitialise controller storage |

## Verification
The hardest state to reach is a failing checksum that follows a passing one. That case shows the result bit is rewritten at the end of each test rather than only ever set. The bench reaches it by running two full tests against a ROM model whose words it can offset by a bias between runs. The second run also injects a full-ones write in the middle of the test, to show that the frozen control word and the fixed length survive host traffic. The pattern phases are checked cycle by cycle while the bench alternates the odd-row input, so both parities of both patterns are covered.

// File: rtl/st_pkg.sv
package st_pkg;

    localparam int CW_W      = 8;
    localparam int START_BIT = 6;
    localparam int PASS_BIT  = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SWEEP,
        PH_CHECK,
        PH_INVERSE,
        PH_TAIL
    } phase_e;

endpackage

// File: rtl/st_sum_acc.sv
module st_sum_acc #(
    parameter int DW = 8,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [SW-1:0] sum
);

    logic [SW-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr) begin
            sum_d = '0;
        end else if (en) begin
            sum_d = sum_q + SW'(din);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign sum = sum_q;

endmodule

// File: rtl/st_pattern.sv
module st_pattern #(
    parameter int COLS = 5
) (
    input  logic            on_chk,
    input  logic            on_inv,
    input  logic            odd_row,
    output logic            force_on,
    output logic [COLS-1:0] cols
);

    assign force_on = on_chk | on_inv;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam logic COL_ODD = (c % 2) == 1;
        assign cols[c] = force_on & ((COL_ODD ^ odd_row) == on_inv);
    end

endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
    import st_pkg::*;
#(
    parameter int              ROM_AW     = 7,
    parameter int              ROM_DW     = 8,
    parameter int              SUM_W      = 16,
    parameter logic [SUM_W-1:0] EXPECT_SUM = 'h3A5C,
    parameter int              COLS       = 5,
    parameter int              PAT_LEN    = 114688,
    parameter int              TEST_LEN   = 262144
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CW_W-1:0]   ctl_wdata,
    output logic [CW_W-1:0]   ctl_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [ROM_DW-1:0] rom_data,
    input  logic              scan_odd_row,
    output logic              pat_force,
    output logic [COLS-1:0]   pat_cols,
    output logic              busy,
    output logic              pass,
    output logic              init_req
);

    localparam int DEPTH   = 1 << ROM_AW;
    localparam int CNT_W   = $clog2(TEST_LEN);
    localparam int CHK_END = DEPTH + PAT_LEN;
    localparam int INV_END = DEPTH + 2 * PAT_LEN;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TEST_LEN - 1);

    typedef struct packed {
        logic             busy;
        logic             pass;
        logic             init;
        logic [CW_W-1:0]  ctl;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t           s_d, s_q;
    phase_e        phase;
    logic          start_req;
    logic [SUM_W-1:0] sum;

    always_comb begin
        phase = PH_IDLE;
        if (s_q.busy) begin
            if (s_q.cnt < CNT_W'(DEPTH))        phase = PH_SWEEP;
            else if (s_q.cnt < CNT_W'(CHK_END)) phase = PH_CHECK;
            else if (s_q.cnt < CNT_W'(INV_END)) phase = PH_INVERSE;
            else                                phase = PH_TAIL;
        end
    end

    assign start_req = ctl_wr && !s_q.busy && ctl_wdata[START_BIT];

    always_comb begin
        s_d      = s_q;
        s_d.init = 1'b0;
        if (!s_q.busy) begin
            if (ctl_wr) begin
                s_d.ctl           = ctl_wdata;
                s_d.ctl[PASS_BIT] = 1'b0;
                if (ctl_wdata[START_BIT]) begin
                    s_d.busy = 1'b1;
                    s_d.cnt  = '0;
                end
            end
        end else if (s_q.cnt == LAST) begin
            s_d.busy = 1'b0;
            s_d.init = 1'b1;
            s_d.pass = (sum == EXPECT_SUM);
            s_d.ctl  = '0;
            s_d.cnt  = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    st_sum_acc #(
        .DW (ROM_DW),
        .SW (SUM_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_req),
        .en    (phase == PH_SWEEP),
        .din   (rom_data),
        .sum   (sum)
    );

    st_pattern #(
        .COLS (COLS)
    ) u_pat (
        .on_chk   (phase == PH_CHECK),
        .on_inv   (phase == PH_INVERSE),
        .odd_row  (scan_odd_row),
        .force_on (pat_force),
        .cols     (pat_cols)
    );

    assign rom_addr  = (phase == PH_SWEEP) ? s_q.cnt[ROM_AW-1:0] : '0;
    assign busy      = s_q.busy;
    assign pass      = s_q.pass;
    assign init_req  = s_q.init;
    assign ctl_rdata = {s_q.ctl[7:6], s_q.pass, s_q.ctl[4:0]};

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_q.cnt != LAST) |=> busy);

    // R9
    init_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (init_req && (ctl_rdata & 8'hDF) == 8'h00));

    // R9
    init_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> !init_req);

    // R10
    ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctl_rdata));

    // R11
    pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(pass));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SWEEP && s_q.cnt != '0) |-> rom_addr == $past(rom_addr) + 1'b1);

    // R8
    force_in_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_force |-> busy);

endmodule

// File: tb/selftest_seq_test.sv
`timescale 1ns/1ps
module selftest_seq_test;

    localparam int AW   = 4;
    localparam int PL   = 20;
    localparam int TL   = 64;
    localparam int NC   = 5;

    typedef struct packed {
        logic [7:0]    off;
        logic          frc;
        logic [NC-1:0] cols;
    } vec_t;

    // offsets: sweep 0..15, checker 16..35, inverse 36..55, tail 56..63
    // row parity in cycle k is k[0]
    localparam vec_t VEC [10] = '{
        '{8'd0,  1'b0, 5'b00000},
        '{8'd15, 1'b0, 5'b00000},
        '{8'd16, 1'b1, 5'b10101},
        '{8'd17, 1'b1, 5'b01010},
        '{8'd35, 1'b1, 5'b01010},
        '{8'd36, 1'b1, 5'b01010},
        '{8'd37, 1'b1, 5'b10101},
        '{8'd55, 1'b1, 5'b10101},
        '{8'd56, 1'b0, 5'b00000},
        '{8'd63, 1'b0, 5'b00000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic [7:0]    ctl_rdata;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_data;
    logic          scan_odd_row = 1'b0;
    logic          pat_force;
    logic [NC-1:0] pat_cols;
    logic          busy, pass, init_req;
    int            bias = 0;
    int            n_chk = 0;
    int            n_err = 0;

    always #2.5 clk = ~clk;

    assign rom_data = 8'(int'(rom_addr) * 7 + 3 + bias);

    // sum of 7a+3 over a = 0..15 is 888
    selftest_seq #(
        .ROM_AW (AW), .ROM_DW (8), .SUM_W (16), .EXPECT_SUM (16'd888),
        .COLS (NC), .PAT_LEN (PL), .TEST_LEN (TL)
    ) uut (
        .clk (clk), .rst_n (rst_n), .ctl_wr (ctl_wr), .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata), .rom_addr (rom_addr), .rom_data (rom_data),
        .scan_odd_row (scan_odd_row), .pat_force (pat_force),
        .pat_cols (pat_cols), .busy (busy), .pass (pass), .init_req (init_req)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        @(posedge clk);
        #1 ctl_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_test(input logic exp_pass, input logic poke);
        int busy_cnt = 0;
        wr(8'h40);
        chk(ctl_rdata[6] == 1'b1, "R2 start bit", ctl_rdata, 8'h40);
        for (int k = 0; k < TL; k++) begin
            ctl_wr = 1'b0;
            scan_odd_row = k[0];
            #1;
            if (busy) busy_cnt++;
            if (k < (1 << AW))
                chk(rom_addr == AW'(k), "R4 rom_addr", rom_addr, k);
            for (int i = 0; i < 10; i++) begin
                if (int'(VEC[i].off) == k) begin
                    chk(pat_force == VEC[i].frc, "R6/R7/R8 force", pat_force, VEC[i].frc);
                    chk(pat_cols == VEC[i].cols, "R6/R7/R8 cols", pat_cols, VEC[i].cols);
                end
            end
            if (poke && k == 10) begin
                ctl_wr = 1'b1;
                ctl_wdata = 8'hFF;
            end
            if (poke && k == 11)
                chk(ctl_rdata == 8'h60, "R10 write ignored", ctl_rdata, 8'h60);
            @(negedge clk);
        end
        ctl_wr = 1'b0;
        #1;
        chk(busy_cnt == TL, "R3 busy length", busy_cnt, TL);
        chk(busy == 1'b0, "R3 busy low after", busy, 0);
        chk(init_req == 1'b1, "R9 init pulse", init_req, 1);
        chk(ctl_rdata == {2'b00, exp_pass, 5'b0}, "R9/R5 ctl after",
            ctl_rdata, {2'b00, exp_pass, 5'b0});
        chk(pass == exp_pass, "R5 pass", pass, exp_pass);
        @(negedge clk);
        chk(init_req == 1'b0, "R9 single pulse", init_req, 0);
        chk(pat_force == 1'b0 && pat_cols == '0, "R8 idle pattern", pat_cols, 0);
    endtask

    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && pass == 0 && init_req == 0, "R1 reset flags",
            {busy, pass, init_req}, 0);
        chk(ctl_rdata == 8'h00, "R1 reset ctl", ctl_rdata, 0);
        chk(pat_force == 0 && pat_cols == '0, "R1 reset pattern", pat_cols, 0);

        wr(8'h9F);
        chk(ctl_rdata == 8'h9F, "R12 stored bits", ctl_rdata, 8'h9F);
        chk(busy == 1'b0, "R12 no start", busy, 0);
        wr(8'h20);
        chk(ctl_rdata == 8'h00, "R11 bit5 not writable", ctl_rdata, 0);

        bias = 0;
        run_test(1'b1, 1'b0);
        wr(8'h20);
        chk(pass == 1'b1, "R11 pass kept", pass, 1);

        bias = 1;
        run_test(1'b0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule